// File: doc/BRIEF.md
# Indexed Postbyte Effective-Address Unit

This unit sits between the operand-fetch sequencer and the execute stage of an 8-bit processor core. When an instruction uses indexed addressing, the sequencer hands over the postbyte, the four pointer registers, the accumulators and the address of the byte that follows the postbyte. The unit decodes the postbyte and fetches any offset bytes from the instruction stream. When the postbyte asks for indirection, it reads a 16-bit pointer from memory. It then returns the final 16-bit effective address.

Reads go over a simple byte interface. The unit raises a request with an address and holds both until a read-valid beat returns the data byte. For the auto-increment and auto-decrement forms, the unit also returns the new pointer value, which register it belongs to, and a write-back enable. Reserved encodings finish at once with an illegal flag and cause no reads and no write-back.

A job starts with a one-cycle `start` while `busy` is low. It ends with a one-cycle `done`. All results are valid only in the `done` cycle.

Top module: `idx_ea_unit`

## Requirements
- R1: With postbyte bit 7 clear, bits 6..5 pick the pointer register (00 X, 01 Y, 10 U, 11 S). The address is that pointer plus bits 4..0 read as a signed value from -16 to +15. No byte is read and there is no write-back.
- R2: With bit 7 set and bit 4 clear, the low nibble selects the mode. Nibble 0100 gives the pointer itself. Nibble 0110 adds A sign-extended, 0101 adds B sign-extended, and 1011 adds D = {A,B}. None of these forms reads memory or writes the pointer back.
- R3: Nibble 1000 reads one offset byte at `pc_in` and sign-extends it. Nibble 1001 reads two offset bytes, the high byte at `pc_in` and the low byte at `pc_in`+1. The offset is added to the selected pointer.
- R4: Nibble 0000 (step 1) and nibble 0001 (step 2) post-increment. The address is the old pointer, `wb_value` is pointer+step, `wb_en` is 1 and `wb_sel` equals bits 6..5.
- R5: Nibble 0010 (step 1) and nibble 0011 (step 2) pre-decrement. Both the address and `wb_value` are pointer−step, with `wb_en` set to 1.
- R6: Nibble 1100 (8-bit offset) and nibble 1101 (16-bit offset) are PC-relative. The base is `pc_in` plus the number of offset bytes, and bits 6..5 have no effect.
- R7: With bit 7 and bit 4 set, the address computed as above is used to read two bytes, high byte first at that address and low byte at address+1. Those two bytes form the result. For the step-2 auto forms the write-back still happens.
- R8: Postbyte 0x9F reads a 16-bit pointer at `pc_in`/`pc_in`+1 and then reads the result through that pointer, four reads in all.
- R9: The following postbytes raise `illegal` in the `done` cycle with no reads and `wb_en` low: indirect step-1 auto forms (nibble 0000 or 0010 with bit 4 set), nibbles 0111, 1010 and 1110, and nibble 1111 in any postbyte other than 0x9F.
- R10: `rd_req` stays high with a stable `rd_addr` until `rd_valid` is seen. `done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin decoding `postbyte` (taken while not busy) |
| postbyte | input | 8 | Indexed-mode postbyte |
| ptr_x | input | 16 | Pointer register X |
| ptr_y | input | 16 | Pointer register Y |
| ptr_u | input | 16 | Pointer register U |
| ptr_s | input | 16 | Pointer register S |
| pc_in | input | 16 | Address of the byte after the postbyte |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | 16 | Byte read address |
| rd_valid | input | 1 | Read data present this cycle |
| rd_data | input | 8 | Read data byte |
| busy | output | 1 | A job is in progress |
| done | output | 1 | Result valid this cycle |
| ea | output | 16 | Final effective address |
| illegal | output | 1 | Reserved postbyte encoding |
| wb_en | output | 1 | Write `wb_value` back to the pointer |
| wb_sel | output | 2 | Pointer to write back (00 X, 01 Y, 10 U, 11 S) |
| wb_value | output | 16 | New pointer value |

## Verification
The bench targets the sign handling at the edges of each offset. A 5-bit value of −2, the accumulator A holding 0xF0, and an 8-bit byte of 0x91 are each wrong by a multiple of 256 or 32 if they are zero-extended. The bench also checks the PC-relative base against the stream position after the offset bytes, a point that an off-by-one design misses by one or two. Indirect step-2 forms must both read through the pointer and write it back. Reserved codes, the 0x9F form and a 0xBF look-alike are run to catch decoders that issue reads or write back on illegal input. The read responder varies its latency, so a design that moves its address early reads the wrong bytes.

// File: rtl/idx_ea_unit.sv
module idx_ea_unit #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    postbyte,
  input  logic [AW-1:0] ptr_x,
  input  logic [AW-1:0] ptr_y,
  input  logic [AW-1:0] ptr_u,
  input  logic [AW-1:0] ptr_s,
  input  logic [AW-1:0] pc_in,
  input  logic [7:0]    acc_a,
  input  logic [7:0]    acc_b,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [7:0]    rd_data,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          illegal,
  output logic          wb_en,
  output logic [1:0]    wb_sel,
  output logic [AW-1:0] wb_value
);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_EVAL, S_IND, S_FIN} st_t;

  function automatic logic [1:0] off_len(input logic [7:0] p);
    if (p == 8'h9F) return 2'd2;
    if (!p[7]) return 2'd0;
    case (p[3:0])
      4'b1000, 4'b1100: return 2'd1;
      4'b1001, 4'b1101: return 2'd2;
      default:          return 2'd0;
    endcase
  endfunction

  function automatic logic code_bad(input logic [7:0] p);
    if (!p[7]) return 1'b0;
    case (p[3:0])
      4'b0000, 4'b0010: return p[4];
      4'b0001, 4'b0011, 4'b0100, 4'b0101, 4'b0110,
      4'b1000, 4'b1001, 4'b1011, 4'b1100, 4'b1101: return 1'b0;
      4'b1111: return p != 8'h9F;
      default: return 1'b1;
    endcase
  endfunction

  st_t           state;
  logic [7:0]    pb_q;
  logic [AW-1:0] base_q, pc_q, ptr_q, off_q, ea_q, wbv_q;
  logic [7:0]    a_q, b_q;
  logic [1:0]    cnt_q;
  logic          ill_q, wb_q;

  logic [3:0]    nib;
  logic [1:0]    len;
  logic          ind;
  logic [AW-1:0] off_ext, calc, step, wb_next, sel_ptr;

  assign nib     = pb_q[3:0];
  assign len     = off_len(pb_q);
  assign ind     = pb_q[7] & pb_q[4];
  assign off_ext = (len == 2'd1) ? {{(AW-8){off_q[7]}}, off_q[7:0]} : off_q;
  assign step    = nib[0] ? AW'(2) : AW'(1);
  assign wb_next = nib[1] ? base_q - step : base_q + step;

  always_comb begin
    case (postbyte[6:5])
      2'b00:   sel_ptr = ptr_x;
      2'b01:   sel_ptr = ptr_y;
      2'b10:   sel_ptr = ptr_u;
      default: sel_ptr = ptr_s;
    endcase
  end

  always_comb begin
    calc = base_q;
    if (!pb_q[7]) calc = base_q + {{(AW-5){pb_q[4]}}, pb_q[4:0]};
    else begin
      case (nib)
        4'b0010: calc = base_q - AW'(1);
        4'b0011: calc = base_q - AW'(2);
        4'b0101: calc = base_q + {{(AW-8){b_q[7]}}, b_q};
        4'b0110: calc = base_q + {{(AW-8){a_q[7]}}, a_q};
        4'b1011: calc = base_q + {{(AW-16){1'b0}}, a_q, b_q};
        4'b1000, 4'b1001: calc = base_q + off_ext;
        4'b1100, 4'b1101: calc = pc_q + AW'(len) + off_ext;
        4'b1111: calc = off_q;
        default: calc = base_q;
      endcase
    end
  end

  assign rd_req   = (state == S_FETCH) || (state == S_IND);
  assign rd_addr  = ((state == S_FETCH) ? pc_q : ptr_q) + AW'(cnt_q);
  assign busy     = state != S_IDLE;
  assign done     = state == S_FIN;
  assign ea       = ea_q;
  assign illegal  = done & ill_q;
  assign wb_en    = done & wb_q;
  assign wb_sel   = pb_q[6:5];
  assign wb_value = wbv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      pb_q   <= '0;
      base_q <= '0;
      pc_q   <= '0;
      ptr_q  <= '0;
      off_q  <= '0;
      ea_q   <= '0;
      wbv_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      cnt_q  <= '0;
      ill_q  <= 1'b0;
      wb_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          pb_q   <= postbyte;
          base_q <= sel_ptr;
          pc_q   <= pc_in;
          a_q    <= acc_a;
          b_q    <= acc_b;
          cnt_q  <= '0;
          off_q  <= '0;
          ea_q   <= '0;
          wb_q   <= 1'b0;
          ill_q  <= code_bad(postbyte);
          if (code_bad(postbyte))           state <= S_FIN;
          else if (off_len(postbyte) != 0)  state <= S_FETCH;
          else                              state <= S_EVAL;
        end
        S_FETCH: if (rd_valid) begin
          off_q <= {off_q[AW-9:0], rd_data};
          if (cnt_q == len - 2'd1) begin
            cnt_q <= '0;
            state <= S_EVAL;
          end else cnt_q <= cnt_q + 2'd1;
        end
        S_EVAL: begin
          wb_q  <= pb_q[7] && (nib[3:2] == 2'b00);
          wbv_q <= wb_next;
          cnt_q <= '0;
          if (ind) begin
            ptr_q <= calc;
            state <= S_IND;
          end else begin
            ea_q  <= calc;
            state <= S_FIN;
          end
        end
        S_IND: if (rd_valid) begin
          ea_q <= {ea_q[AW-9:0], rd_data};
          if (cnt_q == 2'd1) state <= S_FIN;
          else cnt_q <= cnt_q + 2'd1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_no_wb_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wb_en);
  a_r9_bad_finishes: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && code_bad(postbyte) |=> done && illegal);
  a_r1_short_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !postbyte[7] |=> !rd_req);
  a_r4_wb_auto_only: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> pb_q[7] && pb_q[3:2] == 2'b00);

endmodule

// File: tb/idx_ea_unit_test.sv
module idx_ea_unit_test;
  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] postbyte = 0, acc_a = 8'hF0, acc_b = 8'h05;
  logic [15:0] ptr_x = 16'h1000, ptr_y = 16'h2000, ptr_u = 16'h3000, ptr_s = 16'h4000;
  logic [15:0] pc_in = 16'h8000;
  logic rd_req, rd_valid = 0, busy, done, illegal, wb_en;
  logic [7:0] rd_data = 0;
  logic [15:0] rd_addr, ea, wb_value;
  logic [1:0] wb_sel;
  int checks = 0, failures = 0, beats = 0, lat = 0, waitc = 0, cyc = 0;

  always #10 clk = ~clk;

  idx_ea_unit uut (.clk, .rst_n, .start, .postbyte, .ptr_x, .ptr_y, .ptr_u, .ptr_s,
    .pc_in, .acc_a, .acc_b, .rd_req, .rd_addr, .rd_valid, .rd_data, .busy, .done,
    .ea, .illegal, .wb_en, .wb_sel, .wb_value);

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] + a[15:8] + 8'h11;
  endfunction
  function automatic logic [15:0] mem16(input logic [15:0] a);
    return {mem(a), mem(a + 16'd1)};
  endfunction

  always @(negedge clk) begin
    if (rd_req && !rd_valid) begin
      if (waitc >= lat) begin
        rd_valid <= 1; rd_data <= mem(rd_addr); beats <= beats + 1;
        waitc <= 0; lat <= (lat + 1) % 3;
      end else waitc <= waitc + 1;
    end else rd_valid <= 0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [7:0] pb, input logic [15:0] exp_ea,
                     input logic exp_ill, input logic exp_wb, input logic [15:0] exp_wbv,
                     input int exp_beats);
    int t = 0;
    @(negedge clk);
    postbyte = pb; start = 1; beats = 0;
    @(negedge clk);
    start = 0;
    while (!done && t < 200) begin @(negedge clk); t++; end
    chk({req, " done"}, {31'b0, done}, 1);
    if (!exp_ill) chk({req, " ea"}, ea, exp_ea);
    chk({req, " illegal"}, illegal, exp_ill);
    chk({req, " wb_en"}, wb_en, exp_wb);
    if (exp_wb) begin
      chk({req, " wb_value"}, wb_value, exp_wbv);
      chk({req, " wb_sel"}, wb_sel, pb[6:5]);
    end
    chk({req, " reads"}, beats, exp_beats);
    @(negedge clk);
    chk({req, " done pulse R10"}, done, 0);
  endtask

  task automatic t_reset;
    chk("reset busy", busy, 0);
    chk("reset done", done, 0);
    chk("reset rd_req", rd_req, 0);
  endtask

  task automatic t_short;
    run("R1 Y-2", 8'h3E, 16'h1FFE, 0, 0, 0, 0);
    run("R1 X+15", 8'h0F, 16'h100F, 0, 0, 0, 0);
    run("R1 S-16", 8'h70, 16'h3FF0, 0, 0, 0, 0);
  endtask

  task automatic t_acc;
    run("R2 X none", 8'h84, 16'h1000, 0, 0, 0, 0);
    run("R2 S+A", 8'hE6, 16'h3FF0, 0, 0, 0, 0);
    run("R2 U+B", 8'hC5, 16'h3005, 0, 0, 0, 0);
    run("R2 X+D", 8'h8B, 16'h0005, 0, 0, 0, 0);
  endtask

  task automatic t_const;
    run("R3 X+8bit", 8'h88, 16'h0F91, 0, 0, 0, 1);
    run("R3 U+16bit", 8'hC9, 16'hC192, 0, 0, 0, 2);
  endtask

  task automatic t_auto;
    run("R4 X+", 8'h80, 16'h1000, 0, 1, 16'h1001, 0);
    run("R4 S++", 8'hE1, 16'h4000, 0, 1, 16'h4002, 0);
    run("R5 U-", 8'hC2, 16'h2FFF, 0, 1, 16'h2FFF, 0);
    run("R5 Y--", 8'hA3, 16'h1FFE, 0, 1, 16'h1FFE, 0);
  endtask

  task automatic t_pcrel;
    run("R6 pc8", 8'h8C, 16'h7F92, 0, 0, 0, 1);
    run("R6 pc16 regbits", 8'hED, 16'h1194, 0, 0, 0, 2);
  endtask

  task automatic t_indirect;
    run("R7 [X]", 8'h94, mem16(16'h1000), 0, 0, 0, 2);
    run("R7 [U++]", 8'hD1, mem16(16'h3000), 0, 1, 16'h3002, 2);
    run("R7 [--U]", 8'hD3, mem16(16'h2FFE), 0, 1, 16'h2FFE, 2);
    run("R7 [pc8]", 8'h9C, mem16(16'h7F92), 0, 0, 0, 3);
    run("R8 ext ind", 8'h9F, mem16(16'h9192), 0, 0, 0, 4);
  endtask

  task automatic t_illegal;
    run("R9 [X+]", 8'h90, 0, 1, 0, 0, 0);
    run("R9 [-X]", 8'h92, 0, 1, 0, 0, 0);
    run("R9 0111", 8'h87, 0, 1, 0, 0, 0);
    run("R9 1010", 8'hAA, 0, 1, 0, 0, 0);
    run("R9 1110", 8'h8E, 0, 1, 0, 0, 0);
    run("R9 BF", 8'hBF, 0, 1, 0, 0, 0);
    run("R9 8F", 8'h8F, 0, 1, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_short; t_acc; t_const; t_auto; t_pcrel; t_indirect; t_illegal;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule